// File: doc/BRIEF.md
# Interrupt Redirection Pin Controller

This block collects interrupt events from 24 input pins and turns each serviced pin into one delivery message. Every pin has its own redirection entry: a vector, a delivery mode, a polarity flag, a trigger mode, a mask bit and an 8-bit destination. Each pin also holds a request bit and a read-only pending flag that marks a level-triggered interrupt the receiver has taken but not yet retired. Level pins follow the state of their input. Edge pins latch one request per asserting event. An end-of-interrupt broadcast carries a vector. It retires every pending level entry with that vector, and a pin whose request is still up is then delivered again.

Software programs the entries through a plain side port. A write is one cycle with `cfg_wr` high. A read is combinational on `cfg_idx`/`cfg_hi`. Messages leave on a valid/ready port. Once `msg_valid` is high, the vector, level flag, delivery mode and destination stay frozen until a cycle with `msg_ready` high. The message register reloads in that same cycle, so one message per clock can leave while `msg_ready` stays high. An event sampled at a clock edge can appear on `msg_valid` after the following edge, if the message register is free.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset every entry reads masked (low word 0x0001_0000, high word 0), no request or pending flag is set and `msg_valid` is low.
- R2: Low word layout: vector [7:0], delivery mode [10:8], pending flag [12] (read-only), polarity [14], trigger [15] (1 = level), mask [16]. High word: destination [31:24]. Indices 24 and above read as 0 and ignore writes.
- R3: An event on input 0 acts on pin 2. Events on inputs 24 and above change nothing.
- R4: On an edge pin, an event with level 1 sets the request only while the pin is unmasked. An event on a masked edge pin is discarded, so unmasking the pin later delivers nothing.
- R5: Delivering an edge pin clears its request, so each accepted edge event yields exactly one message.
- R6: On a level pin, level 1 sets the request and level 0 clears it. Delivery sets the pending flag. While the flag is set, the pin emits no message.
- R7: An end-of-interrupt with vector V clears the pending flag of every entry that has the flag set and vector V. Such a pin with its request still set and unmasked is delivered again. Other vectors have no effect.
- R8: A masked pin keeps its request and is not delivered. Unmasking it with the request still set delivers it.
- R9: Among eligible pins the lowest index is taken first, and at most one pin is taken per clock.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and all message fields hold their values.
- R11: Writing a low word with trigger 0 clears that entry's pending flag.
- R12: An edge event on a pin in the same cycle that pin is taken into the message register leaves its request set, so a second message follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Pin event strobe |
| evt_num | input | 5 | Input number of the event |
| evt_level | input | 1 | Level carried by the event |
| cfg_wr | input | 1 | Entry word write strobe |
| cfg_idx | input | 5 | Entry index for read and write |
| cfg_hi | input | 1 | Selects the high word (1) or the low word (0) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected word |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_level | output | 1 | Message trigger mode (1 = level) |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dest | output | 8 | Message destination |

## Verification
Two collisions are the focus. The first is a stalled message being consumed in the same cycle that the next pin is taken. This is provoked by holding `msg_ready` low over three pending edge pins and then releasing it. The run is judged by the accepted order and by the frozen payload during the stall. The second is a fresh edge event landing on the very pin being taken. This is provoked by driving that event in the cycle `msg_ready` rises, and it is judged by a duplicate message for that pin. A sweep over every input number, including the remapped and the out-of-range ones, checks each delivered vector, mode and destination against values computed from the pin number.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 8;
  localparam int DM_W   = 3;
  localparam int DEST_W = 8;

  localparam int B_DM    = 8;
  localparam int B_RPEND = 12;
  localparam int B_POL   = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;
  localparam int B_DEST  = 24;

  typedef struct packed {
    logic              mask;
    logic              level;
    logic              pol;
    logic [DM_W-1:0]   dmode;
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
  } entry_t;
endpackage

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
  parameter int N  = 24,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  assign found  = |req;
  assign onehot = req & (~req + N'(1));

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_pin_slot.sv
module irq_pin_slot
  import irq_redir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_hit,
  input  logic              evt_level,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              take,
  output entry_t            ent,
  output logic              req,
  output logic              rpend,
  output logic              elig
);
  entry_t ent_n;
  logic   req_n, rpend_n;

  assign elig = req && !ent.mask && !(ent.level && rpend);

  always_comb begin
    req_n = req;
    if (take && !ent.level) req_n = 1'b0;
    if (evt_hit) begin
      if (ent.level)                   req_n = evt_level;
      else if (evt_level && !ent.mask) req_n = 1'b1;
    end
  end

  always_comb begin
    rpend_n = rpend;
    if (take && ent.level) rpend_n = 1'b1;
    if (eoi_valid && rpend && eoi_vector == ent.vec) rpend_n = 1'b0;
    if (wr_lo && !wdata[B_TRIG]) rpend_n = 1'b0;
  end

  always_comb begin
    ent_n = ent;
    if (wr_lo) begin
      ent_n.vec   = wdata[VEC_W-1:0];
      ent_n.dmode = wdata[B_DM +: DM_W];
      ent_n.pol   = wdata[B_POL];
      ent_n.level = wdata[B_TRIG];
      ent_n.mask  = wdata[B_MASK];
    end
    if (wr_hi) ent_n.dest = wdata[B_DEST +: DEST_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent      <= '0;
      ent.mask <= 1'b1;
      req      <= 1'b0;
      rpend    <= 1'b0;
    end else begin
      ent   <= ent_n;
      req   <= req_n;
      rpend <= rpend_n;
    end
  end
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS  = 24,
  parameter int IN_W      = 5,
  parameter int REMAP_SRC = 0,
  parameter int REMAP_DST = 2,
  localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [IN_W-1:0]   evt_num,
  input  logic              evt_level,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_hi,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [VEC_W-1:0]  msg_vector,
  output logic              msg_level,
  output logic [DM_W-1:0]   msg_dmode,
  output logic [DEST_W-1:0] msg_dest
);
  entry_t              ents [NUM_PINS];
  logic [NUM_PINS-1:0] req_vec, rpend_vec, elig_vec, mask_vec, level_vec;
  logic [NUM_PINS-1:0] take_vec, pick_1h;
  logic [IDX_W-1:0]    pick_idx;
  logic                pick_found, msg_load;
  logic [IN_W-1:0]     evt_pin;
  logic                evt_ok, cfg_ok;

  assign evt_pin = (evt_num == IN_W'(REMAP_SRC)) ? IN_W'(REMAP_DST) : evt_num;
  assign evt_ok  = evt_valid && ({1'b0, evt_pin} < (IN_W+1)'(NUM_PINS));
  assign cfg_ok  = {1'b0, cfg_idx} < (IDX_W+1)'(NUM_PINS);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irq_pin_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_hit    (evt_ok && evt_pin == IN_W'(g)),
      .evt_level  (evt_level),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .wr_lo      (cfg_wr && cfg_ok && !cfg_hi && cfg_idx == IDX_W'(g)),
      .wr_hi      (cfg_wr && cfg_ok && cfg_hi && cfg_idx == IDX_W'(g)),
      .wdata      (cfg_wdata),
      .take       (take_vec[g]),
      .ent        (ents[g]),
      .req        (req_vec[g]),
      .rpend      (rpend_vec[g]),
      .elig       (elig_vec[g])
    );
    assign mask_vec[g]  = ents[g].mask;
    assign level_vec[g] = ents[g].level;
  end

  irq_first_pick #(.N(NUM_PINS)) u_pick (
    .req    (elig_vec),
    .found  (pick_found),
    .idx    (pick_idx),
    .onehot (pick_1h)
  );

  assign msg_load = pick_found && (!msg_valid || msg_ready);
  assign take_vec = msg_load ? pick_1h : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_level  <= 1'b0;
      msg_dmode  <= '0;
      msg_dest   <= '0;
    end else if (msg_load) begin
      msg_valid  <= 1'b1;
      msg_vector <= ents[pick_idx].vec;
      msg_level  <= ents[pick_idx].level;
      msg_dmode  <= ents[pick_idx].dmode;
      msg_dest   <= ents[pick_idx].dest;
    end else if (msg_ready) begin
      msg_valid  <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_ok) begin
      if (cfg_hi) begin
        cfg_rdata[B_DEST +: DEST_W] = ents[cfg_idx].dest;
      end else begin
        cfg_rdata[VEC_W-1:0]   = ents[cfg_idx].vec;
        cfg_rdata[B_DM +: DM_W] = ents[cfg_idx].dmode;
        cfg_rdata[B_RPEND]     = rpend_vec[cfg_idx];
        cfg_rdata[B_POL]       = ents[cfg_idx].pol;
        cfg_rdata[B_TRIG]      = ents[cfg_idx].level;
        cfg_rdata[B_MASK]      = ents[cfg_idx].mask;
      end
    end
  end
endmodule

// File: rtl/irq_redirect_ctrl_chk.sv
module irq_redirect_ctrl_chk
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IN_W     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                evt_valid,
  input logic [IN_W-1:0]     evt_num,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [VEC_W-1:0]    msg_vector,
  input logic                msg_level,
  input logic [DM_W-1:0]     msg_dmode,
  input logic [DEST_W-1:0]   msg_dest,
  input logic                msg_load,
  input logic [NUM_PINS-1:0] take_vec,
  input logic [NUM_PINS-1:0] mask_vec,
  input logic [NUM_PINS-1:0] level_vec,
  input logic [NUM_PINS-1:0] rpend_vec,
  input logic [NUM_PINS-1:0] req_vec
);
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable({msg_vector, msg_level, msg_dmode, msg_dest})); // R10
  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec)); // R9
  AST_LOAD_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    msg_load |=> msg_valid); // R9
  AST_TAKE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec & mask_vec) == '0); // R8
  AST_NO_REDELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vec & level_vec & rpend_vec) == '0); // R6
  AST_EDGE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (rpend_vec & ~level_vec) == '0); // R11
  AST_IGNORED_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && ({1'b0, evt_num} >= (IN_W+1)'(NUM_PINS)) && !msg_load |=> $stable(req_vec)); // R3
endmodule

bind irq_redirect_ctrl irq_redirect_ctrl_chk #(.NUM_PINS(NUM_PINS), .IN_W(IN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_valid  (evt_valid),
  .evt_num    (evt_num),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_vector (msg_vector),
  .msg_level  (msg_level),
  .msg_dmode  (msg_dmode),
  .msg_dest   (msg_dest),
  .msg_load   (msg_load),
  .take_vec   (take_vec),
  .mask_vec   (mask_vec),
  .level_vec  (level_vec),
  .rpend_vec  (rpend_vec),
  .req_vec    (req_vec)
);

// File: tb/irq_redirect_ctrl_tb.sv
module irq_redirect_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_num = '0;
  logic        evt_level = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic        cfg_hi = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [7:0]  msg_vector;
  logic        msg_level;
  logic [2:0]  msg_dmode;
  logic [7:0]  msg_dest;

  int errors = 0;
  int checks = 0;
  logic [19:0] got [256];
  int n_got = 0;
  int n_rd = 0;

  always #10 clk = ~clk;

  irq_redirect_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_num(evt_num),
    .evt_level(evt_level), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_hi(cfg_hi),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_level(msg_level), .msg_dmode(msg_dmode),
    .msg_dest(msg_dest)
  );

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready && n_got < 256) begin
      got[n_got] = {msg_level, msg_dmode, msg_dest, msg_vector};
      n_got = n_got + 1;
    end
  end

  function automatic logic [19:0] mk(input logic lvl, input logic [2:0] dm,
                                     input logic [7:0] dst, input logic [7:0] v);
    return {lvl, dm, dst, v};
  endfunction

  function automatic logic [31:0] lo_word(input logic msk, input logic lvl,
                                          input logic [2:0] dm, input logic [7:0] v);
    return (32'(msk) << 16) | (32'(lvl) << 15) | (32'(dm) << 8) | 32'(v);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n = 4);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic hi, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 5'(idx); cfg_hi = hi; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input int idx, input logic hi, output logic [31:0] d);
    @(negedge clk);
    cfg_idx = 5'(idx); cfg_hi = hi;
    #1 d = cfg_rdata;
  endtask

  task automatic evt(input int num, input logic lvl);
    @(negedge clk);
    evt_valid = 1'b1; evt_num = 5'(num); evt_level = lvl;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic expect_next(input string req, input logic [19:0] exp);
    if (n_rd >= n_got) begin
      checks++; errors++;
      $display("FAIL %s: actual=none expected=%h", req, exp);
    end else begin
      check(req, 32'(got[n_rd]), 32'(exp));
      n_rd++;
    end
  endtask

  task automatic expect_none(input string req);
    check(req, 32'(n_got - n_rd), 32'd0);
    n_rd = n_got;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5, 1'b0, v); check("R1 lo", v, 32'h0001_0000);
    rd(5, 1'b1, v); check("R1 hi", v, 32'h0);
    check("R1 valid", 32'(msg_valid), 32'd0);

    // R2 out-of-range index
    wr(24, 1'b0, 32'h0000_00AB);
    rd(24, 1'b0, v); check("R2 oob", v, 32'h0);

    // Sweep: program all pins as unmasked edge pins
    for (int p = 0; p < 24; p++) begin
      wr(p, 1'b0, lo_word(1'b0, 1'b0, 3'(p), 8'(32 + p)));
      wr(p, 1'b1, 32'(p) << 24);
    end
    rd(7, 1'b1, v); check("R2 hi", v, 32'h0700_0000);
    rd(9, 1'b0, v); check("R2 lo", v, lo_word(1'b0, 1'b0, 3'd1, 8'h29));

    // R3 R5 every input number
    for (int i = 0; i < 24; i++) begin
      int p;
      p = (i == 0) ? 2 : i;
      evt(i, 1'b1);
      settle();
      expect_next("R3 R5 sweep", mk(1'b0, 3'(p), 8'(p), 8'(32 + p)));
    end
    settle();
    expect_none("R5 single");
    for (int i = 24; i < 32; i++) evt(i, 1'b1);
    settle();
    expect_none("R3 ignored");

    // R4 masked edge discarded
    wr(3, 1'b0, lo_word(1'b1, 1'b0, 3'd3, 8'h23));
    evt(3, 1'b1);
    wr(3, 1'b0, lo_word(1'b0, 1'b0, 3'd3, 8'h23));
    settle();
    expect_none("R4 masked edge");

    // R6 R7 level pin
    wr(5, 1'b0, lo_word(1'b0, 1'b1, 3'd1, 8'h45));
    evt(5, 1'b1);
    settle();
    expect_next("R6 level", mk(1'b1, 3'd1, 8'd5, 8'h45));
    rd(5, 1'b0, v); check("R6 pend", v, 32'h0000_9145);
    evt(5, 1'b1);
    settle();
    expect_none("R6 blocked");
    eoi(8'h46);
    settle();
    expect_none("R7 other vector");
    rd(5, 1'b0, v); check("R7 other vector pend", v, 32'h0000_9145);
    eoi(8'h45);
    settle();
    expect_next("R7 redeliver", mk(1'b1, 3'd1, 8'd5, 8'h45));
    evt(5, 1'b0);
    eoi(8'h45);
    settle();
    expect_none("R6 low level");
    rd(5, 1'b0, v); check("R7 cleared", v, 32'h0000_8145);

    // R11 switching to edge clears pending; request still high gives one edge message
    evt(5, 1'b1);
    settle();
    expect_next("R11 level", mk(1'b1, 3'd1, 8'd5, 8'h45));
    wr(5, 1'b0, lo_word(1'b0, 1'b0, 3'd1, 8'h45));
    settle();
    rd(5, 1'b0, v); check("R11 pend", v, 32'h0000_0145);
    expect_next("R11 edge", mk(1'b0, 3'd1, 8'd5, 8'h45));

    // R8 masked level keeps request
    wr(7, 1'b0, lo_word(1'b1, 1'b1, 3'd0, 8'h77));
    evt(7, 1'b1);
    settle();
    expect_none("R8 masked");
    wr(7, 1'b0, lo_word(1'b0, 1'b1, 3'd0, 8'h77));
    settle();
    expect_next("R8 unmask", mk(1'b1, 3'd0, 8'd7, 8'h77));
    evt(7, 1'b0);
    eoi(8'h77);

    // R9 R10 order and back-pressure
    @(negedge clk); msg_ready = 1'b0;
    evt(9, 1'b1); evt(4, 1'b1); evt(12, 1'b1);
    settle();
    check("R10 valid", 32'(msg_valid), 32'd1);
    check("R10 vec", 32'(msg_vector), 32'h29);
    settle(5);
    check("R10 hold", 32'(msg_vector), 32'h29);
    @(negedge clk); msg_ready = 1'b1;
    settle();
    expect_next("R9 first", mk(1'b0, 3'd1, 8'd9, 8'h29));
    expect_next("R9 second", mk(1'b0, 3'd4, 8'd4, 8'h24));
    expect_next("R9 third", mk(1'b0, 3'd4, 8'd12, 8'h2C));

    // R12 event collides with take of the same pin
    @(negedge clk); msg_ready = 1'b0;
    evt(9, 1'b1); evt(10, 1'b1);
    settle();
    @(negedge clk);
    msg_ready = 1'b1; evt_valid = 1'b1; evt_num = 5'd10; evt_level = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    settle();
    expect_next("R12 first", mk(1'b0, 3'd1, 8'd9, 8'h29));
    expect_next("R12 take", mk(1'b0, 3'd2, 8'd10, 8'h2A));
    expect_next("R12 again", mk(1'b0, 3'd2, 8'd10, 8'h2A));
    settle();
    expect_none("R12 end");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule